// File: doc/BRIEF.md
# Erased Sector Zero-Bit Screen

This block sits beside a NAND error-correction decoder and settles one question: when the decoder gives up on a sector because it reports more bit errors than it can repair, is that sector in fact blank? A freshly erased sector reads as all ones in both its data and its stored check bytes. Its check bytes are then not a valid code word for all-ones data, so the decoder sees a mass of errors even though nothing is wrong. The screen counts the bits that read as 0 over the data bytes and over the stored check bytes. A few stray zero bits are allowed, up to the correction limit. If the sector is within that limit, the block declares it erased and produces a clean all-ones copy of the data.

The sector arrives as one byte per cycle. Each byte carries a valid strobe, a first and a last marker, and a tag that says whether it belongs to the data region or the check region. The decoder's error count is sampled with the first byte. Data-region bytes are forwarded one cycle later. One cycle after the last byte, a single done pulse carries the outcome: erased, uncorrectable, or not applicable (both flags low). After an erased outcome the block emits one all-ones byte per cycle, as many bytes as a sector holds, and holds off its input meanwhile.

Top module: `ezd_top`

## Requirements
- R1: A synchronous active-high reset clears the output stream, the done pulse and both outcome flags, and leaves `accept` high.
- R2: Every bit that reads 0 in an accepted byte adds one to the zero count of its region (data region when `in_is_ecc`=0, check region when 1), and the verdict uses the sum of the two region counts.
- R3: Each region count saturates at LIMIT+1 and never wraps, so 17 zero bits in one region still yield an uncorrectable verdict.
- R4: The screen is armed only when the `err_count` sampled with the first byte is greater than LIMIT; an unarmed sector still gives the done pulse but with both flags low.
- R5: For an armed sector whose summed zero count is LIMIT or less, `sector_done` and `res_erased` are high for exactly one cycle, the cycle after the last byte is accepted.
- R6: For an armed sector whose summed zero count exceeds LIMIT, `sector_done` and `res_fail` pulse together in that same cycle; `res_erased` and `res_fail` are never high together.
- R7: Each accepted data-region byte appears unchanged on `out_byte` with `out_valid`=1 and `out_fill`=0 one cycle after acceptance; check-region bytes are not forwarded.
- R8: After an erased verdict, exactly DATA_BYTES bytes of 0xFF appear on consecutive cycles with `out_valid`=1 and `out_fill`=1, starting the cycle after the done pulse.
- R9: While the all-ones bytes are being produced, `accept` is low and any input byte presented is ignored: it is not forwarded and does not disturb the fill.
- R10: A byte flagged first restarts both region counts, so zero bits from an earlier sector never reach a later verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_count | input | ERR_W | Decoder error count, sampled with the first byte |
| in_valid | input | 1 | Input byte strobe |
| in_first | input | 1 | Marks the first byte of a sector |
| in_last | input | 1 | Marks the last byte of a sector (a check-region byte) |
| in_is_ecc | input | 1 | 0 = data region, 1 = check region |
| in_byte | input | 8 | Input byte |
| accept | output | 1 | Low while the all-ones fill runs; input ignored then |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Forwarded data byte or 0xFF fill byte |
| out_fill | output | 1 | High when the output byte is a fill byte |
| sector_done | output | 1 | One-cycle pulse after the last byte |
| res_erased | output | 1 | Sector judged blank (with done) |
| res_fail | output | 1 | Sector judged truly uncorrectable (with done) |

## Verification
The bench sweeps zero counts of 0 to 10 in each region against each other, so the LIMIT/LIMIT+1 boundary is crossed from every split. A design that judged each region alone, or compared with the wrong inequality, gives the wrong flag on the diagonal near 8. Runs of 17 and of all zero bits in a single region catch a counter that wraps instead of saturating, since a wrapped count would pass as erased. A sweep of the error count over every value around the limit catches an off-by-one in arming. Back-to-back sectors and bytes pushed during the fill catch counts that leak across sectors, a fill of the wrong length, and a fill that lets input bytes through.

// File: rtl/ezd_pkg.sv
package ezd_pkg;
  localparam logic REGION_DATA = 1'b0;
  localparam logic REGION_ECC  = 1'b1;

  // number of bits that read as 0 in one byte
  function automatic logic [3:0] zero_bits(input logic [7:0] b);
    return 4'($countones(~b));
  endfunction
endpackage

// File: rtl/ezd_zero_count.sv
module ezd_zero_count #(
  parameter int LIMIT = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          hit,
  input  logic [7:0]    byte_in,
  output logic [CW-1:0] cnt_nxt
);
  import ezd_pkg::*;
  localparam int SAT = LIMIT + 1;
  localparam int AW  = CW + 4;

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] base;
  logic [AW-1:0] sum;

  always_comb begin
    base = restart ? '0 : AW'(cnt_q);
    sum  = base + (hit ? AW'(zero_bits(byte_in)) : '0);
    cnt_nxt = (sum > AW'(SAT)) ? CW'(SAT) : sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/ezd_fill.sv
module ezd_fill #(
  parameter int DATA_BYTES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic filling
);
  localparam int FW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam logic [FW-1:0] LAST = FW'(DATA_BYTES - 1);

  logic [FW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      filling <= 1'b0;
      idx     <= '0;
    end else if (start) begin
      filling <= 1'b1;
      idx     <= '0;
    end else if (filling) begin
      if (idx == LAST) filling <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/ezd_top.sv
module ezd_top #(
  parameter int DATA_BYTES = 512,
  parameter int LIMIT      = 8,
  parameter int ERR_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] err_count,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             in_is_ecc,
  input  logic [7:0]       in_byte,
  output logic             accept,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_fill,
  output logic             sector_done,
  output logic             res_erased,
  output logic             res_fail
);
  localparam int SAT = LIMIT + 1;
  localparam int CW  = $clog2(SAT + 1);

  logic          filling;
  logic          acc;
  logic          en_q;
  logic          en_now;
  logic          en_eff;
  logic          closing;
  logic          blank;
  logic [CW:0]   total;
  logic [CW-1:0] cnt_nxt [2];

  assign accept  = ~filling;
  assign acc     = in_valid & ~filling;
  assign en_now  = {1'b0, err_count} > (ERR_W + 1)'(LIMIT);
  assign en_eff  = in_first ? en_now : en_q;
  assign closing = acc & in_last;

  // one saturating zero counter per region
  for (genvar r = 0; r < 2; r++) begin : g_region
    ezd_zero_count #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .restart (acc & in_first),
      .hit     (acc & (in_is_ecc == 1'(r))),
      .byte_in (in_byte),
      .cnt_nxt (cnt_nxt[r])
    );
  end

  assign total = {1'b0, cnt_nxt[0]} + {1'b0, cnt_nxt[1]};
  assign blank = total <= (CW + 1)'(LIMIT);

  ezd_fill #(.DATA_BYTES(DATA_BYTES)) u_fill (
    .clk     (clk),
    .rst     (rst),
    .start   (closing & en_eff & blank),
    .filling (filling)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q        <= 1'b0;
      sector_done <= 1'b0;
      res_erased  <= 1'b0;
      res_fail    <= 1'b0;
      out_valid   <= 1'b0;
      out_byte    <= '0;
      out_fill    <= 1'b0;
    end else begin
      if (acc & in_first) en_q <= en_now;
      sector_done <= closing;
      res_erased  <= closing & en_eff & blank;
      res_fail    <= closing & en_eff & ~blank;
      out_valid   <= filling | (acc & (in_is_ecc == ezd_pkg::REGION_DATA));
      out_byte    <= filling ? 8'hFF : in_byte;
      out_fill    <= filling;
    end
  end
endmodule

// File: rtl/ezd_chk.sv
module ezd_chk #(
  parameter int DATA_BYTES = 512
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_is_ecc,
  input logic [7:0] in_byte,
  input logic       accept,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_fill,
  input logic       sector_done,
  input logic       res_erased,
  input logic       res_fail
);
  int run;

  always_ff @(posedge clk) begin
    if (rst)           run <= 0;
    else if (out_fill) run <= run + 1;
    else               run <= 0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !sector_done && !res_erased && !res_fail && accept));

  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (res_erased || res_fail) |-> (sector_done && !(res_erased && res_fail)));

  // R7
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fill) |->
      ($past(in_valid && accept && !in_is_ecc) && out_byte == $past(in_byte)));

  // R8
  fill_start_chk: assert property (@(posedge clk) disable iff (rst)
    (sector_done && res_erased) |=> (out_valid && out_fill && out_byte == 8'hFF));

  // R8
  fill_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_fill && run != 0) |-> (run == DATA_BYTES));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (out_valid && out_fill));
endmodule

bind ezd_top ezd_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_ecc(in_is_ecc),
  .in_byte(in_byte), .accept(accept), .out_valid(out_valid),
  .out_byte(out_byte), .out_fill(out_fill), .sector_done(sector_done),
  .res_erased(res_erased), .res_fail(res_fail)
);

// File: tb/sim_ezd_top.sv
`timescale 1ns/1ps
module sim_ezd_top;
  localparam int DB  = 16;
  localparam int EB  = 3;
  localparam int LIM = 8;
  localparam int EW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [EW-1:0] err_count = '0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_is_ecc = 1'b0;
  logic [7:0] in_byte = '0;
  logic accept, out_valid, out_fill, sector_done, res_erased, res_fail;
  logic [7:0] out_byte;

  always #2 clk = ~clk;

  ezd_top #(.DATA_BYTES(DB), .LIMIT(LIM), .ERR_W(EW)) u0 (
    .clk(clk), .rst(rst), .err_count(err_count), .in_valid(in_valid),
    .in_first(in_first), .in_last(in_last), .in_is_ecc(in_is_ecc),
    .in_byte(in_byte), .accept(accept), .out_valid(out_valid),
    .out_byte(out_byte), .out_fill(out_fill), .sector_done(sector_done),
    .res_erased(res_erased), .res_fail(res_fail)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // output monitor: running totals only
  int pass_total = 0, fill_total = 0, fill_bad = 0;
  int done_total = 0, er_total = 0, fl_total = 0;
  logic [7:0] got [0:8191];

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_fill) begin
        fill_total++;
        if (out_byte != 8'hFF) fill_bad++;
      end else if (out_valid) begin
        got[pass_total % 8192] = out_byte;
        pass_total++;
      end
      if (sector_done) done_total++;
      if (res_erased)  er_total++;
      if (res_fail)    fl_total++;
    end
  end

  logic [7:0] dbuf [DB];
  logic [7:0] ebuf [EB];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic build(input int dz, input int ez, input int seed);
    for (int i = 0; i < DB; i++) dbuf[i] = 8'hFF;
    for (int i = 0; i < EB; i++) ebuf[i] = 8'hFF;
    for (int k = 0; k < dz; k++) begin
      int p = (seed + k) % (DB * 8);
      dbuf[p / 8][p % 8] = 1'b0;
    end
    for (int k = 0; k < ez; k++) begin
      int p = (seed * 3 + k) % (EB * 8);
      ebuf[p / 8][p % 8] = 1'b0;
    end
  endtask

  task automatic drive(input logic f, input logic l, input logic e, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_last = l; in_is_ecc = e; in_byte = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic send(input int err, input bit gap);
    err_count = EW'(err);
    for (int i = 0; i < DB; i++) begin
      drive(i == 0, 1'b0, 1'b0, dbuf[i]);
      if (gap && (i % 3 == 2)) idle();
    end
    for (int i = 0; i < EB; i++) drive(1'b0, i == EB - 1, 1'b1, ebuf[i]);
    idle();
  endtask

  // send one sector and compare every observable against the model
  task automatic sector(input int err, input int dz, input int ez, input bit gap, input string tag);
    int p0, f0, d0, e0, x0, sd, se, tot;
    bit armed, ers, fl;
    build(dz, ez, dz * 7 + ez + err);
    p0 = pass_total; f0 = fill_total; d0 = done_total; e0 = er_total; x0 = fl_total;
    send(err, gap);
    repeat (DB + 6) @(negedge clk);
    #1;
    sd = (dz > LIM + 1) ? LIM + 1 : dz;
    se = (ez > LIM + 1) ? LIM + 1 : ez;
    tot = sd + se;
    armed = err > LIM;
    ers = armed && tot <= LIM;
    fl  = armed && tot > LIM;
    chk(done_total - d0 == 1, {tag, " R5 done pulse count"}, done_total - d0, 1);
    chk(er_total - e0 == int'(ers), {tag, " R2 R4 R5 erased flag"}, er_total - e0, int'(ers));
    chk(fl_total - x0 == int'(fl), {tag, " R3 R4 R6 fail flag"}, fl_total - x0, int'(fl));
    chk(pass_total - p0 == DB, {tag, " R7 forwarded count"}, pass_total - p0, DB);
    for (int i = 0; i < DB; i++)
      chk(got[(p0 + i) % 8192] == dbuf[i], {tag, " R7 forwarded byte"},
          int'(got[(p0 + i) % 8192]), int'(dbuf[i]));
    chk(fill_total - f0 == (ers ? DB : 0), {tag, " R8 fill length"}, fill_total - f0, ers ? DB : 0);
    chk(fill_bad == 0, {tag, " R8 fill value"}, fill_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 0 && sector_done == 0 && res_erased == 0 && res_fail == 0,
        "R1 outputs after reset", int'(out_valid) + int'(sector_done), 0);
    chk(accept == 1, "R1 accept after reset", int'(accept), 1);
    rst = 1'b0;
    @(negedge clk);

    // R2: both regions swept across the limit boundary
    for (int dz = 0; dz <= 10; dz++)
      for (int ez = 0; ez <= 10; ez++)
        sector(12, dz, ez, (dz + ez) % 2 == 1, "R2 sweep");

    // R4: arming threshold over every error count
    for (int err = 0; err < 16; err++) sector(err, 1, 1, 1'b0, "R4 low zeros");
    for (int err = 0; err < 16; err++) sector(err, 12, 0, 1'b0, "R4 high zeros");

    // R3: saturation, no wrap
    sector(9, 17, 0, 1'b0, "R3 data 17");
    sector(9, 0, 17, 1'b0, "R3 ecc 17");
    sector(9, DB * 8, EB * 8, 1'b0, "R3 all zero");
    sector(15, 16, 0, 1'b1, "R3 data 16");

    // R10: a full-limit sector followed by a one-bit sector
    sector(10, 8, 0, 1'b0, "R10 first");
    sector(10, 0, 1, 1'b0, "R10 second");

    // R9: bytes offered during the fill are dropped
    begin
      int p0, f0;
      build(0, 0, 0);
      p0 = pass_total; f0 = fill_total;
      err_count = 4'd12;
      for (int i = 0; i < DB; i++) drive(i == 0, 1'b0, 1'b0, dbuf[i]);
      for (int i = 0; i < EB; i++) drive(1'b0, i == EB - 1, 1'b1, ebuf[i]);
      for (int k = 0; k < 6; k++) begin
        drive(1'b1, 1'b0, 1'b0, 8'h00);
        #1;
        if (k > 0) chk(accept == 0, "R9 accept low during fill", int'(accept), 0);
      end
      idle();
      repeat (DB + 4) @(negedge clk);
      #1;
      chk(pass_total - p0 == DB, "R9 no extra forwarded bytes", pass_total - p0, DB);
      chk(fill_total - f0 == DB, "R9 fill undisturbed", fill_total - f0, DB);
      chk(accept == 1, "R9 accept back high", int'(accept), 1);
    end
    sector(12, 3, 2, 1'b0, "R10 after ignored bytes");

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule